// File: doc/BRIEF.md
# Banked I2C Serial EEPROM Controller

This block is the I2C target side of a 4-Kbit serial memory that is split into two 256-byte banks. Only one bank is visible to the bus at a time. An 8-bit word address selects a byte inside that bank. The block oversamples the bus lines with the system clock and runs the bus protocol. Write data goes into a 16-byte page buffer. When the stop condition arrives, the buffer is committed to the array, one byte per clock, during a fixed busy window.

Three kinds of read are supported: current-address, random and sequential. A second device-type code carries one-byte commands. These commands switch the visible bank, query which bank is visible, protect any of the four 128-byte quarters, and clear that protection. A write-protect input pin blocks every array write. The array itself is plain registers.

Top module: `eep_bank_ctrl`

## Requirements
- R1: The block acknowledges an address byte of the form 1010_ppp_r, where ppp equals `dev_sel_i`. It gives no acknowledge for any other device-type code (except the command code 0110 of R5, R6 and R8) or for a mismatching ppp.
- R2: After reset, bank 0 is visible, no quarter is protected and `sda_oe_o` is low. The bus is released (`sda_oe_o` low) whenever no transfer is addressed to the block.
- R3: A write message is: address byte with r=0, word address, then data bytes. Each data byte is stored at {bank, page, low}, and the low 4 bits wrap inside the 16-byte page.
- R4: A read returns the byte at the internal pointer and then increments the pointer. The pointer rolls over from 0xFF to 0x00 of the same bank. A random read (word address, repeated start, read) starts at the given address.
- R5: The command byte 0110_110_0 selects bank 0 and 0110_111_0 selects bank 1. Both are acknowledged, and a further byte in the same message is not acknowledged. The query byte 0110_110_1 is acknowledged only while bank 0 is visible.
- R6: The command byte 0110_0qq_0 protects quarter qq. The quarter number is {bank, word address bit 7}. Writes into a protected quarter are acknowledged but leave the array unchanged.
- R7: While `wp_i` is high, writes are acknowledged but leave the array unchanged.
- R8: The clear command 0110_100_0 removes all quarter protection only when `wp_i` is low. With `wp_i` high it is not acknowledged and has no effect.
- R9: After a stop that ends a write with at least one data byte, every address byte is left unacknowledged for BUSY_CYCLES clocks. After that window it is acknowledged again.
- R10: After a write, the pointer is one past the last written byte, wrapped inside its page. A write message that holds only a word address moves the pointer and starts no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| dev_sel_i | input | 3 | Strap value compared with address bits 3:1 |
| wp_i | input | 1 | Write-protect pin, high blocks array writes |
| sda_oe_o | output | 1 | Pulls the data line low when high |

## Verification
The bench builds the block with BUSY_CYCLES set to 300 instead of the default 5000, and keeps a 16-byte page and two synchroniser stages. The shorter window lets the bench probe the address byte while the block is still busy and again once the window is over, all within a few hundred clocks. This gives both sides of R9 on every write. With the 16-byte page, a five-byte write starting at offset 0x1E wraps back to 0x10, so one short message shows the page boundary.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEVACK,
    S_WORD,
    S_WORDACK,
    S_WR,
    S_WRACK,
    S_RD,
    S_RDACK
  } bus_st_e;

  localparam logic [3:0] MEM_TYPE  = 4'b1010;
  localparam logic [3:0] CMD_TYPE  = 4'b0110;
  localparam logic [2:0] SUB_CLR   = 3'b100;
  localparam logic [2:0] SUB_BANK0 = 3'b110;
  localparam logic [2:0] SUB_BANK1 = 3'b111;

endpackage

// File: rtl/eep_bus_sense.sv
module eep_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  assign scl_s = scl_q[SYNC_STAGES-1];
  assign sda_s = sda_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eep_page_store.sv
module eep_page_store #(
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 5000,
  parameter int ARR_W       = 9,
  parameter int QW          = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            buf_clr,
  input  logic                            buf_we,
  input  logic [$clog2(PAGE_BYTES)-1:0]   buf_idx,
  input  logic [7:0]                      buf_din,
  input  logic                            commit_go,
  input  logic [ARR_W-$clog2(PAGE_BYTES)-1:0] page_sel,
  input  logic                            wp_i,
  input  logic [(1<<QW)-1:0]              prot,
  input  logic [ARR_W-1:0]                rd_addr,
  output logic [7:0]                      rd_data,
  output logic                            busy
);

  localparam int DEPTH = 1 << ARR_W;
  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [IDX_W:0] PAGE_END = (IDX_W+1)'(PAGE_BYTES);

  logic [7:0]            arr [DEPTH];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid, pvalid_n;
  logic [CNT_W-1:0]      cnt, cnt_n;
  logic [IDX_W:0]        cidx, cidx_n;
  logic [ARR_W-1:0]      waddr;
  logic                  arr_we;

  assign busy    = (cnt != '0);
  assign rd_data = arr[rd_addr];

  always_comb begin
    waddr    = {page_sel, cidx[IDX_W-1:0]};
    arr_we   = busy && (cidx < PAGE_END) && pvalid[cidx[IDX_W-1:0]] &&
               !wp_i && !prot[waddr[ARR_W-1 -: QW]];
    pvalid_n = pvalid;
    if (buf_clr)     pvalid_n = '0;
    else if (buf_we) pvalid_n[buf_idx] = 1'b1;
    cnt_n  = cnt;
    cidx_n = cidx;
    if (commit_go) begin
      cnt_n  = CNT_W'(BUSY_CYCLES);
      cidx_n = '0;
    end else if (busy) begin
      cnt_n = cnt - 1'b1;
      if (cidx < PAGE_END) cidx_n = cidx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvalid <= '0;
      cnt    <= '0;
      cidx   <= PAGE_END;
    end else begin
      pvalid <= pvalid_n;
      cnt    <= cnt_n;
      cidx   <= cidx_n;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_din;
  end

  always_ff @(posedge clk) begin
    if (arr_we) arr[waddr] <= pbuf[cidx[IDX_W-1:0]];
  end

  // R9: the page is fully drained before the busy window closes
  assert_drain_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cidx < PAGE_END) |-> busy);

  // R9: no new buffer fill can overlap a commit
  assert_no_fill_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !buf_we);

endmodule

// File: rtl/eep_bank_ctrl.sv
module eep_bank_ctrl
  import eep_pkg::*;
#(
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);

  localparam int WORD_W   = 8;
  localparam int BANKS    = 2;
  localparam int ARR_W    = WORD_W + $clog2(BANKS);
  localparam int IDX_W    = $clog2(PAGE_BYTES);
  localparam int QW       = $clog2(BANKS) + 1;
  localparam int QUARTERS = 1 << QW;

  logic [1:0] rst_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign srst_n = rst_q[1];

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  eep_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) sense_i (
    .clk(clk), .rst_n(srst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  bus_st_e             st, st_n;
  logic [3:0]          bitcnt, bitcnt_n;
  logic [7:0]          shreg, sh_n;
  logic [WORD_W-1:0]   ptr, ptr_n;
  logic                bank, bank_n;
  logic                rw_q, rw_n, cmd_q, cmd_n, oe_q, oe_n;
  logic                wpend, wpend_n, mnack, mnack_n;
  logic [QUARTERS-1:0] prot, prot_n;
  logic                buf_clr, buf_we, commit_go, cmd_ok, busy;
  logic [7:0]          rd_data;
  logic [3:0]          dtype;
  logic [2:0]          dsub;

  assign dtype    = shreg[7:4];
  assign dsub     = shreg[3:1];
  assign sda_oe_o = oe_q;

  eep_page_store #(
    .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES), .ARR_W(ARR_W), .QW(QW)
  ) store_i (
    .clk(clk), .rst_n(srst_n), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_idx(ptr[IDX_W-1:0]), .buf_din(shreg), .commit_go(commit_go),
    .page_sel({bank, ptr[WORD_W-1:IDX_W]}), .wp_i(wp_i), .prot(prot),
    .rd_addr({bank, ptr}), .rd_data(rd_data), .busy(busy)
  );

  always_comb begin
    st_n = st; bitcnt_n = bitcnt; sh_n = shreg; ptr_n = ptr; bank_n = bank;
    rw_n = rw_q; cmd_n = cmd_q; oe_n = oe_q; wpend_n = wpend; mnack_n = mnack;
    prot_n = prot; buf_clr = 1'b0; buf_we = 1'b0; commit_go = 1'b0; cmd_ok = 1'b0;
    if (stop_ev) begin
      st_n = S_IDLE; oe_n = 1'b0; commit_go = wpend; wpend_n = 1'b0;
    end else if (start_ev) begin
      st_n = S_DEV; bitcnt_n = '0; oe_n = 1'b0;
    end else begin
      case (st)
        S_DEV, S_WORD, S_WR: begin
          if (scl_rise) begin
            sh_n = {shreg[6:0], sda_s};
            bitcnt_n = bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (st == S_DEV) begin
              if (busy) begin
                st_n = S_IDLE;
              end else if (dtype == MEM_TYPE && dsub == dev_sel_i) begin
                oe_n = 1'b1; rw_n = shreg[0]; cmd_n = 1'b0; st_n = S_DEVACK;
              end else if (dtype == CMD_TYPE) begin
                if (!shreg[0]) begin
                  if (!dsub[2]) begin
                    prot_n[dsub[QW-1:0]] = 1'b1; cmd_ok = 1'b1;
                  end else if (dsub == SUB_CLR && !wp_i) begin
                    prot_n = '0; cmd_ok = 1'b1;
                  end else if (dsub == SUB_BANK0) begin
                    bank_n = 1'b0; cmd_ok = 1'b1;
                  end else if (dsub == SUB_BANK1) begin
                    bank_n = 1'b1; cmd_ok = 1'b1;
                  end
                end else if (dsub == SUB_BANK0 && !bank) begin
                  cmd_ok = 1'b1;
                end
                oe_n  = cmd_ok;
                cmd_n = 1'b1;
                st_n  = cmd_ok ? S_DEVACK : S_IDLE;
              end else begin
                st_n = S_IDLE;
              end
            end else if (st == S_WORD) begin
              ptr_n = shreg; buf_clr = 1'b1; oe_n = 1'b1; st_n = S_WORDACK;
            end else begin
              buf_we = 1'b1; wpend_n = 1'b1; oe_n = 1'b1; st_n = S_WRACK;
              ptr_n = {ptr[WORD_W-1:IDX_W], ptr[IDX_W-1:0] + 1'b1};
            end
          end
        end
        S_DEVACK: if (scl_fall) begin
          bitcnt_n = '0;
          if (cmd_q) begin
            oe_n = 1'b0; st_n = S_IDLE;
          end else if (rw_q) begin
            sh_n = rd_data; oe_n = ~rd_data[7]; st_n = S_RD;
          end else begin
            oe_n = 1'b0; st_n = S_WORD;
          end
        end
        S_WORDACK, S_WRACK: if (scl_fall) begin
          oe_n = 1'b0; bitcnt_n = '0; st_n = S_WR;
        end
        S_RD: if (scl_fall) begin
          if (bitcnt == 4'd7) begin
            oe_n = 1'b0; ptr_n = ptr + 1'b1; st_n = S_RDACK;
          end else begin
            bitcnt_n = bitcnt + 4'd1;
            sh_n = {shreg[6:0], 1'b0};
            oe_n = ~shreg[6];
          end
        end
        S_RDACK: begin
          if (scl_rise) begin
            mnack_n = sda_s;
          end else if (scl_fall) begin
            if (mnack) begin
              st_n = S_IDLE;
            end else begin
              sh_n = rd_data; oe_n = ~rd_data[7]; bitcnt_n = '0; st_n = S_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st <= S_IDLE; bitcnt <= '0; shreg <= '0; ptr <= '0; bank <= 1'b0;
      rw_q <= 1'b0; cmd_q <= 1'b0; oe_q <= 1'b0; wpend <= 1'b0;
      mnack <= 1'b0; prot <= '0;
    end else begin
      st <= st_n; bitcnt <= bitcnt_n; shreg <= sh_n; ptr <= ptr_n; bank <= bank_n;
      rw_q <= rw_n; cmd_q <= cmd_n; oe_q <= oe_n; wpend <= wpend_n;
      mnack <= mnack_n; prot <= prot_n;
    end
  end

  // R2: line released whenever no transfer is addressed here
  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (st == S_IDLE) |-> !oe_q);

  // R9: an address acknowledge never comes out of the busy window
  assert_busy_nack_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (st == S_DEVACK && $past(st) == S_DEV && !cmd_q) |-> !$past(busy));

  // R5: the bank only moves on a decoded command byte
  assert_bank_by_cmd_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (bank != $past(bank)) |-> ($past(st) == S_DEV && !$past(busy)));

  // R8: protection is removed only with the pin low
  assert_clear_pin_low_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (|($past(prot) & ~prot)) |-> !$past(wp_i));

endmodule

// File: tb/eep_bank_ctrl_tb_top.sv
module eep_bank_ctrl_tb_top;

  localparam int Q    = 5;
  localparam int BUSY = 300;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, PINS, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, PINS, 1'b1};
  localparam logic [7:0] C_B0 = 8'h6C, C_B1 = 8'h6E, C_QRY = 8'h6D, C_CLR = 8'h68;
  localparam int NV = 6;
  // {bank, word address, data}
  localparam logic [16:0] VECS [NV] = '{
    {1'b0, 8'h00, 8'h11}, {1'b0, 8'h3C, 8'h42}, {1'b0, 8'hFF, 8'h5A},
    {1'b1, 8'h00, 8'hE7}, {1'b1, 8'h80, 8'h9C}, {1'b1, 8'hFF, 8'h24}
  };

  logic clk = 1'b0;
  logic rst_n, scl_m, sda_m, wp;
  logic sda_oe, sda_line;
  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  eep_bank_ctrl #(.PAGE_BYTES(16), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_sel_i(PINS), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tq(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start(); sda_m = 1; tq(); scl_m = 1; tq(); sda_m = 0; tq(); scl_m = 0; tq(); endtask
  task automatic i2c_stop(); sda_m = 0; tq(); scl_m = 1; tq(); sda_m = 1; tq(); endtask
  task automatic send_bit(input bit b); sda_m = b; tq(); scl_m = 1; tq(); tq(); scl_m = 0; tq(); endtask
  task automatic recv_bit(output bit b);
    sda_m = 1; tq(); scl_m = 1; tq(); b = sda_line; tq(); scl_m = 0; tq();
  endtask
  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b); ack = !b;
  endtask
  task automatic recv_byte(output logic [7:0] d, input bit more);
    bit b;
    for (int i = 0; i < 8; i++) begin recv_bit(b); d = {d[6:0], b}; end
    send_bit(!more);
  endtask
  task automatic settle(); repeat (BUSY + 100) @(negedge clk); endtask

  task automatic do_cmd(input logic [7:0] c, output bit ack);
    i2c_start(); send_byte(c, ack); i2c_stop(); tq();
  endtask
  task automatic write_seq(input logic [7:0] a, input int n, input logic [7:0] base, output bit allack);
    bit k;
    i2c_start(); send_byte(DEVW, allack); send_byte(a, k); allack &= k;
    for (int i = 0; i < n; i++) begin send_byte(8'(base + i), k); allack &= k; end
    i2c_stop(); tq();
  endtask
  task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
    bit k;
    i2c_start(); send_byte(DEVW, k); send_byte(a, k);
    i2c_start(); send_byte(DEVR, k); recv_byte(d, 0); i2c_stop(); tq();
  endtask
  task automatic seq_read2(input logic [7:0] a, output logic [7:0] d0, output logic [7:0] d1);
    bit k;
    i2c_start(); send_byte(DEVW, k); send_byte(a, k);
    i2c_start(); send_byte(DEVR, k); recv_byte(d0, 1); recv_byte(d1, 0); i2c_stop(); tq();
  endtask
  task automatic cur_read(output logic [7:0] d, output bit ack);
    i2c_start(); send_byte(DEVR, ack);
    if (ack) recv_byte(d, 0);
    i2c_stop(); tq();
  endtask
  task automatic probe(output bit ack);
    i2c_start(); send_byte(DEVW, ack); i2c_stop(); tq();
  endtask

  initial begin
    logic [7:0] d, d2;
    bit a;
    rst_n = 0; scl_m = 1; sda_m = 1; wp = 0;
    repeat (5) @(negedge clk);
    chk("R2 released in reset", int'(sda_oe), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R2 released after reset", int'(sda_oe), 0);
    do_cmd(C_QRY, a); chk("R2 bank0 at reset", int'(a), 1);

    for (int i = 0; i < NV; i++) begin
      do_cmd(VECS[i][16] ? C_B1 : C_B0, a); chk("R5 bank select ack", int'(a), 1);
      write_seq(VECS[i][15:8], 1, VECS[i][7:0], a); chk("R3 write ack", int'(a), 1);
      settle();
      rand_read(VECS[i][15:8], d); chk("R3 R4 readback", int'(d), int'(VECS[i][7:0]));
    end

    seq_read2(8'hFF, d, d2);
    chk("R4 bank1 last byte", int'(d), 'h24); chk("R4 bank1 rollover", int'(d2), 'hE7);
    do_cmd(C_QRY, a); chk("R5 query nack in bank1", int'(a), 0);
    i2c_start(); send_byte(C_B0, a); chk("R5 bank0 ack", int'(a), 1);
    send_byte(8'h00, a); chk("R5 no data byte", int'(a), 0); i2c_stop(); tq();
    seq_read2(8'hFF, d, d2);
    chk("R4 bank0 last byte", int'(d), 'h5A); chk("R4 bank0 rollover", int'(d2), 'h11);

    i2c_start(); send_byte({4'b1010, 3'b001, 1'b0}, a); i2c_stop(); tq();
    chk("R1 pin mismatch nack", int'(a), 0);
    i2c_start(); send_byte(8'h50, a); i2c_stop(); tq();
    chk("R1 foreign type nack", int'(a), 0);
    probe(a); chk("R1 own address ack", int'(a), 1);

    write_seq(8'h20, 1, 8'h66, a); settle();
    write_seq(8'h1E, 5, 8'hA0, a); settle();
    rand_read(8'h10, d); chk("R3 page wrap 0x10", int'(d), 'hA2);
    rand_read(8'h12, d); chk("R3 page wrap 0x12", int'(d), 'hA4);
    rand_read(8'h1E, d); chk("R3 page start", int'(d), 'hA0);
    rand_read(8'h20, d); chk("R3 next page untouched", int'(d), 'h66);

    write_seq(8'h40, 3, 8'hC0, a); settle();
    write_seq(8'h40, 2, 8'hB0, a); settle();
    cur_read(d, a); chk("R10 pointer after write", int'(d), 'hC2);
    i2c_start(); send_byte(DEVW, a); send_byte(8'h41, a); i2c_stop(); tq();
    cur_read(d, a); chk("R10 word-only no busy", int'(a), 1);
    chk("R10 word-only pointer", int'(d), 'hB1);
    cur_read(d, a); chk("R4 current increments", int'(d), 'hC2);

    write_seq(8'h70, 1, 8'h3E, a);
    probe(a); chk("R9 nack while busy", int'(a), 0);
    settle();
    probe(a); chk("R9 ack after window", int'(a), 1);
    rand_read(8'h70, d); chk("R9 committed data", int'(d), 'h3E);

    write_seq(8'h90, 1, 8'h33, a); settle();
    do_cmd(8'h62, a); chk("R6 protect ack", int'(a), 1);
    write_seq(8'h90, 1, 8'h77, a); chk("R6 protected write acked", int'(a), 1);
    settle();
    rand_read(8'h90, d); chk("R6 protected unchanged", int'(d), 'h33);
    write_seq(8'h08, 1, 8'h44, a); settle();
    rand_read(8'h08, d); chk("R6 other quarter writable", int'(d), 'h44);

    wp = 1;
    write_seq(8'h08, 1, 8'h99, a); chk("R7 write acked under pin", int'(a), 1);
    settle();
    rand_read(8'h08, d); chk("R7 pin blocks write", int'(d), 'h44);
    do_cmd(C_CLR, a); chk("R8 clear nack with pin", int'(a), 0);
    wp = 0;
    write_seq(8'h90, 1, 8'h77, a); settle();
    rand_read(8'h90, d); chk("R8 refused clear kept protect", int'(d), 'h33);
    do_cmd(C_CLR, a); chk("R8 clear ack", int'(a), 1);
    write_seq(8'h90, 1, 8'h77, a); settle();
    rand_read(8'h90, d); chk("R8 cleared quarter writable", int'(d), 'h77);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule